// File: doc/BRIEF.md
# Clock Holdover Mode Controller

This block supervises a digitally controlled clock synthesizer and decides, one clock cycle at a time, what its output frequency should follow. It has four modes. In free-run the synthesizer follows its local reference. In locked it tracks, or is acquiring, an input clock. In holdover it replays an averaged frequency taken from earlier history. In holdover-exit it is ramping linearly from the holdover frequency toward a newly found input. Input qualification, the history averager, the loop filter and the ramp generator are outside this block. They reach the controller only through plain flags and strobes.

When every input clock has gone invalid, the controller checks the history-valid flag. If enough history has built up, it enters holdover and strobes the averager's result into the frequency target. If not, it falls back to free-run. As soon as any input turns valid again, it leaves holdover. It requests reacquisition of the lowest-numbered valid input, either directly or through a ramp, and it passes along the chosen pull-in bandwidth. All pins are plain control and status: no data stream crosses this block, so it has no valid/ready interface.

Top module: `clk_holdover_ctrl`

## Requirements
- R1: After reset, `mode_o` is free-run (2'b00), and `hold_load_o`, `ramp_start_o` and `reacq_req_o` are all low.
- R2: In free-run, if the input named by `sel_idx_i` is valid at a clock edge, `mode_o` becomes locked (2'b01) after that edge. `reacq_req_o` then pulses with `reacq_idx_o` equal to `sel_idx_i`. A valid input other than the selected one leaves the mode at free-run.
- R3: In locked, the mode stays locked while at least one input is valid, even if the selected input is invalid.
- R4: In locked, if every input is invalid and `hist_valid_i` is 1, `mode_o` becomes holdover (2'b10) and `hold_load_o` is high for exactly that first holdover cycle.
- R5: In locked, if every input is invalid and `hist_valid_i` is 0, `mode_o` becomes free-run and `hold_load_o` stays low.
- R6: In holdover, if any input is valid and `cfg_ramp_exit_i` is 1, `mode_o` becomes holdover-exit (2'b11). `ramp_start_o` and `reacq_req_o` both pulse, and `reacq_idx_o` is the lowest-numbered valid input.
- R7: In holdover, if any input is valid and `cfg_ramp_exit_i` is 0, `mode_o` becomes locked directly. `reacq_req_o` pulses, `reacq_idx_o` is the lowest valid input, and `ramp_start_o` stays low.
- R8: In holdover-exit, the mode holds until `ramp_done_i` is seen at an edge. The mode then becomes locked.
- R9: Whenever `reacq_req_o` pulses, `reacq_fast_o` equals the `cfg_fastlock_en_i` value sampled at that edge.
- R10: `hold_load_o`, `ramp_start_o` and `reacq_req_o` are single-cycle pulses and are never high on two consecutive cycles.
- R11: In holdover-exit, if every input is invalid, the mode goes to holdover (with a `hold_load_o` pulse) or to free-run, chosen by `hist_valid_i` in the same way as R4 and R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid_i | input | NUM_INPUTS | Per-input clock-valid flags |
| sel_idx_i | input | SEL_W | Index of the selected input |
| hist_valid_i | input | 1 | Averaged history is usable |
| ramp_done_i | input | 1 | Exit ramp has reached its target |
| cfg_ramp_exit_i | input | 1 | 1: ramped exit from holdover, 0: direct pull-in |
| cfg_fastlock_en_i | input | 1 | Use the fast-lock bandwidth for pull-in |
| mode_o | output | 2 | 00 free-run, 01 locked, 10 holdover, 11 holdover-exit |
| hold_load_o | output | 1 | Load the averaged holdover frequency (pulse) |
| ramp_start_o | output | 1 | Start the exit ramp (pulse) |
| reacq_req_o | output | 1 | Request lock acquisition (pulse) |
| reacq_idx_o | output | SEL_W | Input to acquire |
| reacq_fast_o | output | 1 | Pull-in with the fast-lock bandwidth |

## Verification
The bench sweeps every selected index out of free-run and every non-zero valid pattern out of holdover, with both exit styles and both bandwidth settings. This catches a priority encoder that picks the wrong end, or a controller that wakes up on an unselected input. It sets up total loss with history present and absent, both from locked and in the middle of a ramp. A design that ignored the history flag would replay a stale frequency it never had, and one that skipped the ramp-loss path would hang in holdover-exit. It also watches every strobe on the cycle after it fires. A level-held strobe would reload the frequency or restart the ramp over and over.

// File: rtl/clk_holdover_ctrl_pkg.sv
package clk_holdover_ctrl_pkg;
  typedef enum logic [1:0] {
    MODE_FREERUN = 2'b00,
    MODE_LOCKED  = 2'b01,
    MODE_HOLD    = 2'b10,
    MODE_EXIT    = 2'b11
  } ho_mode_e;
endpackage

// File: rtl/ho_prio_enc.sv
module ho_prio_enc #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] vec_i,
  output logic         any_o,
  output logic [W-1:0] idx_o
);
  // lowest set bit wins
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = W'(i);
    end
  end
  assign any_o = |vec_i;

  assert_idx_hits_valid_R6: assert property (@(posedge clk) disable iff (!rst_n)
    any_o |-> vec_i[idx_o]);
endmodule

// File: rtl/ho_loss_detect.sv
module ho_loss_detect #(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0] in_valid_i,
  input  logic [W-1:0] sel_idx_i,
  output logic         sel_ok_o,
  output logic         all_lost_o
);
  always_comb begin
    sel_ok_o = 1'b0;
    if (int'(sel_idx_i) < N) sel_ok_o = in_valid_i[sel_idx_i];
  end
  assign all_lost_o = (in_valid_i == '0);
endmodule

// File: rtl/ho_mode_fsm.sv
module ho_mode_fsm
  import clk_holdover_ctrl_pkg::*;
#(
  parameter int N = 4,
  localparam int W = (N > 1) ? $clog2(N) : 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_ok_i,
  input  logic         all_lost_i,
  input  logic         any_valid_i,
  input  logic [W-1:0] low_idx_i,
  input  logic [W-1:0] sel_idx_i,
  input  logic         hist_valid_i,
  input  logic         ramp_done_i,
  input  logic         cfg_ramp_exit_i,
  input  logic         cfg_fastlock_en_i,
  output ho_mode_e     mode_o,
  output logic         hold_load_o,
  output logic         ramp_start_o,
  output logic         reacq_req_o,
  output logic [W-1:0] reacq_idx_o,
  output logic         reacq_fast_o
);
  ho_mode_e     mode_q, mode_d;
  logic         load_d, ramp_d, req_d;
  logic [W-1:0] idx_d;

  // common fallback when every input has disappeared
  function automatic ho_mode_e fallback(input logic hist);
    return hist ? MODE_HOLD : MODE_FREERUN;
  endfunction

  always_comb begin
    mode_d = mode_q;
    load_d = 1'b0;
    ramp_d = 1'b0;
    req_d  = 1'b0;
    idx_d  = reacq_idx_o;
    unique case (mode_q)
      MODE_FREERUN: if (sel_ok_i) begin
        mode_d = MODE_LOCKED;
        req_d  = 1'b1;
        idx_d  = sel_idx_i;
      end
      MODE_LOCKED: if (all_lost_i) begin
        mode_d = fallback(hist_valid_i);
        load_d = hist_valid_i;
      end
      MODE_HOLD: if (any_valid_i) begin
        mode_d = cfg_ramp_exit_i ? MODE_EXIT : MODE_LOCKED;
        ramp_d = cfg_ramp_exit_i;
        req_d  = 1'b1;
        idx_d  = low_idx_i;
      end
      MODE_EXIT: begin
        if (all_lost_i) begin
          mode_d = fallback(hist_valid_i);
          load_d = hist_valid_i;
        end else if (ramp_done_i) begin
          mode_d = MODE_LOCKED;
        end
      end
      default: mode_d = MODE_FREERUN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q       <= MODE_FREERUN;
      hold_load_o  <= 1'b0;
      ramp_start_o <= 1'b0;
      reacq_req_o  <= 1'b0;
      reacq_idx_o  <= '0;
      reacq_fast_o <= 1'b0;
    end else begin
      mode_q       <= mode_d;
      hold_load_o  <= load_d;
      ramp_start_o <= ramp_d;
      reacq_req_o  <= req_d;
      reacq_idx_o  <= idx_d;
      if (req_d) reacq_fast_o <= cfg_fastlock_en_i;
    end
  end
  assign mode_o = mode_q;

  assert_load_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load_o |=> !hold_load_o);
  assert_ramp_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_start_o |=> !ramp_start_o);
  assert_req_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    reacq_req_o |=> !reacq_req_o);
  assert_load_in_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hold_load_o |-> (mode_q == MODE_HOLD));
  assert_ramp_from_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ramp_start_o |-> (mode_q == MODE_EXIT && $past(mode_q) == MODE_HOLD));
  assert_nohist_freerun_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LOCKED && all_lost_i && !hist_valid_i) |=> (mode_q == MODE_FREERUN));
  assert_exit_waits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_EXIT && !ramp_done_i && any_valid_i) |=> (mode_q == MODE_EXIT));
  assert_locked_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == MODE_LOCKED && any_valid_i) |=> (mode_q == MODE_LOCKED));
endmodule

// File: rtl/clk_holdover_ctrl.sv
module clk_holdover_ctrl
  import clk_holdover_ctrl_pkg::*;
#(
  parameter int NUM_INPUTS = 4,
  localparam int SEL_W = (NUM_INPUTS > 1) ? $clog2(NUM_INPUTS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_INPUTS-1:0] in_valid_i,
  input  logic [SEL_W-1:0]      sel_idx_i,
  input  logic                  hist_valid_i,
  input  logic                  ramp_done_i,
  input  logic                  cfg_ramp_exit_i,
  input  logic                  cfg_fastlock_en_i,
  output logic [1:0]            mode_o,
  output logic                  hold_load_o,
  output logic                  ramp_start_o,
  output logic                  reacq_req_o,
  output logic [SEL_W-1:0]      reacq_idx_o,
  output logic                  reacq_fast_o
);
  logic             sel_ok, all_lost, any_valid;
  logic [SEL_W-1:0] low_idx;
  ho_mode_e         mode;

  ho_loss_detect #(.N(NUM_INPUTS)) u_loss (
    .in_valid_i (in_valid_i),
    .sel_idx_i  (sel_idx_i),
    .sel_ok_o   (sel_ok),
    .all_lost_o (all_lost)
  );

  ho_prio_enc #(.N(NUM_INPUTS)) u_prio (
    .clk   (clk),
    .rst_n (rst_n),
    .vec_i (in_valid_i),
    .any_o (any_valid),
    .idx_o (low_idx)
  );

  ho_mode_fsm #(.N(NUM_INPUTS)) u_fsm (
    .clk               (clk),
    .rst_n             (rst_n),
    .sel_ok_i          (sel_ok),
    .all_lost_i        (all_lost),
    .any_valid_i       (any_valid),
    .low_idx_i         (low_idx),
    .sel_idx_i         (sel_idx_i),
    .hist_valid_i      (hist_valid_i),
    .ramp_done_i       (ramp_done_i),
    .cfg_ramp_exit_i   (cfg_ramp_exit_i),
    .cfg_fastlock_en_i (cfg_fastlock_en_i),
    .mode_o            (mode),
    .hold_load_o       (hold_load_o),
    .ramp_start_o      (ramp_start_o),
    .reacq_req_o       (reacq_req_o),
    .reacq_idx_o       (reacq_idx_o),
    .reacq_fast_o      (reacq_fast_o)
  );
  assign mode_o = mode;
endmodule

// File: tb/clk_holdover_ctrl_tb_top.sv
module clk_holdover_ctrl_tb_top;
  localparam int N = 4;
  localparam int SW = 2;
  localparam logic [1:0] FR = 2'b00, LK = 2'b01, HO = 2'b10, EX = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] in_valid = '0;
  logic [SW-1:0] sel_idx = '0;
  logic hist = 1'b0, rdone = 1'b0, ramp_en = 1'b1, fast = 1'b0;
  logic [1:0] mode;
  logic ld, rs, rq, rf;
  logic [SW-1:0] ridx;
  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  clk_holdover_ctrl #(.NUM_INPUTS(N)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid_i(in_valid), .sel_idx_i(sel_idx),
    .hist_valid_i(hist), .ramp_done_i(rdone), .cfg_ramp_exit_i(ramp_en),
    .cfg_fastlock_en_i(fast), .mode_o(mode), .hold_load_o(ld),
    .ramp_start_o(rs), .reacq_req_o(rq), .reacq_idx_o(ridx), .reacq_fast_o(rf)
  );

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int lowest(logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return 0;
  endfunction

  // free-run -> locked on input s
  task automatic to_locked(int s);
    sel_idx = SW'(s); in_valid = '0; in_valid[s] = 1'b1; step();
    chk("R2 mode", mode, LK); chk("R2 req", rq, 1); chk("R2 idx", ridx, s);
    chk("R9 fast", rf, fast);
    step(); chk("R10 req drop", rq, 0);
  endtask

  task automatic lose_all(logic h, logic [1:0] exp_mode);
    hist = h; in_valid = '0; step();
    chk(h ? "R4 mode" : "R5 mode", mode, exp_mode);
    chk(h ? "R4 load" : "R5 load", ld, h);
    step(); chk("R10 load drop", ld, 0);
  endtask

  initial begin
    repeat (3) step();
    chk("R1 mode", mode, FR); chk("R1 load", ld, 0);
    chk("R1 ramp", rs, 0); chk("R1 req", rq, 0);
    rst_n = 1'b1; step();
    chk("R1 mode after release", mode, FR);

    // R2: unselected valid input does not wake up free-run
    for (int s = 0; s < N; s++) begin
      sel_idx = SW'(s); in_valid = ~(N'(1) << s); step(); step();
      chk("R2 unselected stays", mode, FR); chk("R2 no req", rq, 0);
    end

    for (int s = 0; s < N; s++) begin
      fast = s[0];
      to_locked(s);
      // R3: selected fails but another remains
      in_valid = N'(1) << ((s + 1) % N); step(); step();
      chk("R3 stay locked", mode, LK);
      lose_all(1'b0, FR);
    end

    // holdover exit sweep over every non-zero valid pattern
    for (int p = 1; p < (1 << N); p++) begin
      for (int r = 0; r < 2; r++) begin
        fast = p[0] ^ r[0];
        to_locked(0);
        lose_all(1'b1, HO);
        step(); chk("R4 holds", mode, HO);
        ramp_en = r[0]; rdone = 1'b0;
        in_valid = N'(p); step();
        chk(r ? "R6 mode" : "R7 mode", mode, r ? EX : LK);
        chk(r ? "R6 ramp" : "R7 no ramp", rs, r);
        chk(r ? "R6 req" : "R7 req", rq, 1);
        chk(r ? "R6 idx" : "R7 idx", ridx, lowest(N'(p)));
        chk("R9 fast", rf, fast);
        step(); chk("R10 ramp drop", rs, 0); chk("R10 req drop", rq, 0);
        if (r) begin
          repeat (3) step();
          chk("R8 wait", mode, EX);
          rdone = 1'b1; step(); chk("R8 done", mode, LK);
          rdone = 1'b0;
        end
        lose_all(1'b0, FR);
      end
    end

    // R11: loss during ramp, with and without history
    for (int h = 0; h < 2; h++) begin
      ramp_en = 1'b1;
      to_locked(2);
      lose_all(1'b1, HO);
      in_valid = 4'b0100; step(); chk("R11 in exit", mode, EX);
      hist = h[0]; in_valid = '0; step();
      chk("R11 mode", mode, h ? HO : FR); chk("R11 load", ld, h);
      step(); chk("R11 load drop", ld, 0);
      if (h) begin
        hist = 1'b0; in_valid = 4'b0001; ramp_en = 1'b0; step();
        chk("R7 recover", mode, LK); in_valid = '0; step();
        chk("R5 back", mode, FR);
      end
    end
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (100000) @(posedge clk); n_chk++; n_bad++;
        $display("FAIL watchdog actual=0 expected=1"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule